// File: doc/BRIEF.md
# Two-Entry Receive Buffer with Selectable Overflow Reporting

This block sits between a serial receive shifter and the host side of a serial port. Each completed character arrives as a one-cycle push strobe with its data. The block keeps up to two characters in arrival order and shows the oldest one on a read port. A host read strobe removes that character. A receive-ready flag stays high for as long as any character is waiting, so the host can empty the buffer by reading until the flag drops.

A character pushed while both entries are occupied is lost. A mode input selects how that loss is reported. In immediate mode a sticky overflow bit rises at once. In deferred mode the newest stored entry is marked instead. The loss becomes visible only when the host reaches that entry. At that point the error flag and the overflow bit rise, and the read port returns zero in place of the entry's data.

The overflow bit is cleared by a write-one pulse from the host. Dropping the receiver enable empties the buffer and also clears the overflow bit.

Top module: `rx_hold_fifo`

## Requirements
- R1: The buffer holds up to two characters in arrival order. `rd_data` shows the oldest one, and `rd_strobe` removes it. `rx_ready` is high exactly while at least one character is held.
- R2: If `push_vld` arrives while both entries are held and no read happens in the same cycle, the new character is dropped. The two stored characters are unchanged.
- R3: With `imm_ovf` = 1, a dropped character sets `ovf_status` on the clock edge that samples the push.
- R4: With `imm_ovf` = 0, a dropped character marks the newest stored entry and leaves `ovf_status` unchanged. Further drops keep the same entry marked.
- R5: While a marked entry is the oldest one held, `err_flag` = 1, `ovf_status` = 1, `rx_ready` = 1 and `rd_data` = 0. A write-one clear does not hide this. Reading the marked entry sets the sticky overflow bit.
- R6: Once set, `ovf_status` stays high until an `ovf_clr` pulse, and it reads low from the next cycle. If a set and a clear happen in the same cycle, the set wins.
- R7: While `rx_en` = 0, both entries and their marks are flushed, `ovf_status` is cleared, and pushes and reads are ignored.
- R8: A push and a read in the same cycle on a full buffer is not an overflow. The oldest character leaves, the new character is stored, and `ovf_status` is not set.
- R9: A read strobe on an empty buffer has no effect. `rd_data` reads 0 whenever the buffer is empty.
- R10: After reset the buffer is empty, and `rx_ready`, `err_flag` and `ovf_status` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| rx_en | input | 1 | Receiver enable; low flushes the buffer and clears overflow |
| imm_ovf | input | 1 | 1 = immediate overflow report, 0 = deferred through the buffer |
| push_vld | input | 1 | Character complete strobe from the shifter |
| push_data | input | W (8) | Character from the shifter |
| rd_strobe | input | 1 | Host read; removes the oldest character |
| ovf_clr | input | 1 | Write-one clear of the overflow bit |
| rd_data | output | W (8) | Oldest character; 0 when empty or marked |
| rx_ready | output | 1 | At least one character is waiting |
| err_flag | output | 1 | The oldest entry carries an overflow mark |
| ovf_status | output | 1 | Sticky overflow indication |

## Verification
The bench fills the buffer and overflows it once in immediate mode and again, twice in a row, in deferred mode. This separates an overflow bit that rises on the drop from one that waits for the marked entry to be read, and it shows that a repeated drop does not move the mark. A push and a read together on a full buffer tell a real overflow apart from a slot freed in the same cycle. A clear arriving in the same cycle as a new drop shows that the set wins. A clear while a marked entry is at the front shows that the mark keeps the overflow bit visible. Dropping the enable with a push pending, and resetting partway through a fill, show that both clear the stored state and the overflow bit.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;

  typedef enum logic {
    OVF_DEFERRED  = 1'b0,
    OVF_IMMEDIATE = 1'b1
  } ovf_mode_e;

endpackage

// File: rtl/rx_hold_store.sv
module rx_hold_store #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          tag_newest,
  output logic [W-1:0]  front_data,
  output logic          front_tag,
  output logic [CW-1:0] fill,
  output logic          empty,
  output logic          full
);

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] back_ptr(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [DEPTH-1:0]        tag_q, tag_d;
  logic [DEPTH-1:0]        slot_we;
  logic [PW-1:0]           rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic                    push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && (!full || pop_ok);

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    tag_d    = tag_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
      tag_d    = '0;
    end else begin
      if (pop_ok) rd_ptr_d = step_ptr(rd_ptr_q);
      if (push_ok) begin
        wr_ptr_d         = step_ptr(wr_ptr_q);
        tag_d[wr_ptr_q]  = 1'b0;
      end
      if (tag_newest && !push_ok) tag_d[back_ptr(wr_ptr_q)] = 1'b1;
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      tag_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
      tag_q    <= tag_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot_we[i] = push_ok && (wr_ptr_q == PW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem_q[i] <= push_data;
    end
  end

  assign front_data = mem_q[rd_ptr_q];
  assign front_tag  = tag_q[rd_ptr_q] && !empty;
  assign fill       = cnt_q;

endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic imm_event,
  input  logic pop_tagged,
  input  logic clr,
  input  logic front_err,
  output logic ovf_status
);

  logic ovf_q, ovf_d, set_req;

  assign set_req = rx_en && (imm_event || pop_tagged);

  always_comb begin
    ovf_d = ovf_q;
    if (set_req)          ovf_d = 1'b1;
    else if (clr || !rx_en) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf_status = ovf_q || (front_err && rx_en);

endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rx_hold_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         imm_ovf,
  input  logic         push_vld,
  input  logic [W-1:0] push_data,
  input  logic         rd_strobe,
  input  logic         ovf_clr,
  output logic [W-1:0] rd_data,
  output logic         rx_ready,
  output logic         err_flag,
  output logic         ovf_status
);

  localparam int CW = $clog2(DEPTH + 1);

  ovf_mode_e     mode;
  logic [W-1:0]  front_data;
  logic          front_tag, empty, full;
  logic [CW-1:0] fill;
  logic          push, pop, ovf_event, tag_newest, imm_event, pop_tagged;

  assign mode       = ovf_mode_e'(imm_ovf);
  assign push       = push_vld && rx_en;
  assign pop        = rd_strobe && rx_en && !empty;
  assign ovf_event  = push && full && !pop;
  assign imm_event  = ovf_event && (mode == OVF_IMMEDIATE);
  assign tag_newest = ovf_event && (mode == OVF_DEFERRED);
  assign pop_tagged = pop && front_tag;

  rx_hold_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (!rx_en),
    .push       (push),
    .push_data  (push_data),
    .pop        (pop),
    .tag_newest (tag_newest),
    .front_data (front_data),
    .front_tag  (front_tag),
    .fill       (fill),
    .empty      (empty),
    .full       (full)
  );

  rx_hold_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .imm_event  (imm_event),
    .pop_tagged (pop_tagged),
    .clr        (ovf_clr),
    .front_err  (front_tag),
    .ovf_status (ovf_status)
  );

  assign rx_ready = !empty;
  assign err_flag = front_tag;
  assign rd_data  = (empty || front_tag) ? '0 : front_data;

endmodule

// File: rtl/rx_hold_chk.sv
module rx_hold_chk #(
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          imm_ovf,
  input logic          push_vld,
  input logic          rd_strobe,
  input logic          ovf_clr,
  input logic          rx_ready,
  input logic          err_flag,
  input logic          ovf_status,
  input logic [CW-1:0] fill
);

  AST_PUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && push_vld |=> rx_ready);  // R1

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));  // R2

  AST_IMM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && imm_ovf && push_vld && !rd_strobe && fill == CW'(DEPTH) |=> ovf_status);  // R3

  AST_ERR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && rx_en |-> rx_ready && ovf_status);  // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_status && rx_en && !ovf_clr |=> ovf_status);  // R6

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready && !ovf_status && !err_flag);  // R7

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && push_vld && rd_strobe && fill == CW'(DEPTH) |=> fill == CW'(DEPTH));  // R8

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !rx_ready && rd_strobe && !push_vld |=> !rx_ready);  // R9

endmodule

bind rx_hold_fifo rx_hold_chk #(.DEPTH(DEPTH)) i_rx_hold_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .imm_ovf    (imm_ovf),
  .push_vld   (push_vld),
  .rd_strobe  (rd_strobe),
  .ovf_clr    (ovf_clr),
  .rx_ready   (rx_ready),
  .err_flag   (err_flag),
  .ovf_status (ovf_status),
  .fill       (fill)
);

// File: tb/test_rx_hold_fifo.sv
`timescale 1ns/100ps
module test_rx_hold_fifo;

  logic       clk, rst_n, rx_en, imm_ovf, push_vld, rd_strobe, ovf_clr;
  logic [7:0] push_data, rd_data;
  logic       rx_ready, err_flag, ovf_status;
  int         checks, fails;
  bit         done;

  rx_hold_fifo #(.W(8), .DEPTH(2)) i_rx_hold_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .imm_ovf(imm_ovf),
    .push_vld(push_vld), .push_data(push_data), .rd_strobe(rd_strobe),
    .ovf_clr(ovf_clr), .rd_data(rd_data), .rx_ready(rx_ready),
    .err_flag(err_flag), .ovf_status(ovf_status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req, en imm push rd clr, din, exp rdy err ovf, exp data}
  localparam int NV = 32;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1,  5'b11100, 8'hA1, 3'b100, 8'hA1},  // R1 first push
    {4'd1,  5'b11100, 8'hB2, 3'b100, 8'hA1},  // R1 order kept
    {4'd3,  5'b11100, 8'hC3, 3'b101, 8'hA1},  // R3 immediate overflow
    {4'd2,  5'b11010, 8'h00, 3'b101, 8'hB2},  // R2 C3 was dropped
    {4'd9,  5'b11010, 8'h00, 3'b001, 8'h00},  // R9 empty reads zero
    {4'd6,  5'b11001, 8'h00, 3'b000, 8'h00},  // R6 write-one clear
    {4'd9,  5'b11010, 8'h00, 3'b000, 8'h00},  // R9 read on empty
    {4'd1,  5'b10100, 8'h11, 3'b100, 8'h11},  // R1
    {4'd1,  5'b10100, 8'h22, 3'b100, 8'h11},  // R1
    {4'd4,  5'b10100, 8'h33, 3'b100, 8'h11},  // R4 deferred, no flag yet
    {4'd4,  5'b10100, 8'h44, 3'b100, 8'h11},  // R4 second drop
    {4'd5,  5'b10010, 8'h00, 3'b111, 8'h00},  // R5 marked entry at front
    {4'd6,  5'b10010, 8'h00, 3'b001, 8'h00},  // R6 sticky after read
    {4'd6,  5'b10101, 8'h55, 3'b100, 8'h55},  // R6 cleared
    {4'd1,  5'b10100, 8'h66, 3'b100, 8'h55},  // R1
    {4'd8,  5'b10110, 8'h77, 3'b100, 8'h66},  // R8 push+read full
    {4'd8,  5'b10010, 8'h00, 3'b100, 8'h77},  // R8 77 stored
    {4'd7,  5'b00100, 8'h88, 3'b000, 8'h00},  // R7 disable flushes
    {4'd7,  5'b11100, 8'h99, 3'b100, 8'h99},  // R7 88 was ignored
    {4'd1,  5'b11100, 8'hAA, 3'b100, 8'h99},  // R1
    {4'd3,  5'b11100, 8'hBB, 3'b101, 8'h99},  // R3
    {4'd7,  5'b01000, 8'h00, 3'b000, 8'h00},  // R7 overflow cleared
    {4'd1,  5'b11100, 8'h01, 3'b100, 8'h01},  // R1
    {4'd1,  5'b11100, 8'h02, 3'b100, 8'h01},  // R1
    {4'd6,  5'b11101, 8'h03, 3'b101, 8'h01},  // R6 set beats clear
    {4'd6,  5'b11001, 8'h00, 3'b100, 8'h01},  // R6 clear alone
    {4'd7,  5'b00000, 8'h00, 3'b000, 8'h00},  // R7 flush
    {4'd1,  5'b10100, 8'hD1, 3'b100, 8'hD1},  // R1
    {4'd4,  5'b10100, 8'hD2, 3'b100, 8'hD1},  // R4
    {4'd4,  5'b10100, 8'hD3, 3'b100, 8'hD1},  // R4 D2 marked
    {4'd5,  5'b10010, 8'h00, 3'b111, 8'h00},  // R5 marked at front
    {4'd5,  5'b10001, 8'h00, 3'b111, 8'h00}   // R5 clear does not hide
  };

  task automatic check(input int req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: {rdy,err,ovf,data} actual %b_%h expected %b_%h",
               req, act[10:8], act[7:0], exp[10:8], exp[7:0]);
    end
  endtask

  function automatic logic [10:0] outs();
    return {rx_ready, err_flag, ovf_status, rd_data};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; rx_en = 1'b1; imm_ovf = 1'b1; push_vld = 1'b0;
    push_data = '0; rd_strobe = 1'b0; ovf_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(10, outs(), 11'b000_00000000);  // R10 reset state
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      rx_en     = VEC[k][23];
      imm_ovf   = VEC[k][22];
      push_vld  = VEC[k][21];
      rd_strobe = VEC[k][20];
      ovf_clr   = VEC[k][19];
      push_data = VEC[k][18:11];
      @(posedge clk);
      #1;
      check(int'(VEC[k][27:24]), outs(), VEC[k][10:0]);
    end

    // R5: reading the marked entry leaves the sticky bit set
    @(negedge clk);
    ovf_clr = 1'b0; push_vld = 1'b0; rd_strobe = 1'b1;
    @(posedge clk); #1;
    check(5, outs(), 11'b001_00000000);

    // R10: reset partway through a fill
    @(negedge clk);
    rd_strobe = 1'b0; push_vld = 1'b1; push_data = 8'h5A;
    @(posedge clk); #1;
    check(1, outs(), 11'b101_01011010);
    @(negedge clk);
    push_vld = 1'b0;
    rst_n = 1'b0;
    #1;
    check(10, outs(), 11'b000_00000000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(10, outs(), 11'b000_00000000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule